// File: doc/BRIEF.md
# Unaligned Vector Split Access Unit

The unit performs one side of an unaligned 16-byte vector access over a byte-wide memory port. A request carries an effective address, a load/store flag, a side flag (head or tail) and, for stores, a 128-bit vector. A head access covers the bytes from the address up to the next 16-byte boundary. A tail access covers the bytes from the start of the address's 16-byte block up to the address. The unit issues one byte access per handshake. It then presents the assembled vector, or has written the selected bytes, and pulses `done`.

Lanes that an access does not touch read as zero. A full unaligned 16-byte load is therefore the bitwise OR of a head load at address A and a tail load at A+16. A store of 16 bytes at A is a head store at A followed by a tail store at A+16, both given the same vector. Merging the two halves is left to the caller.

Top module: `vsplit_xfer`

## Requirements
- R1: With shift = addr[3:0], a head access makes exactly 16-shift byte accesses to addr, addr+1, ... in increasing order.
- R2: A head load places the byte from addr+i in lane i for i < 16-shift and zero in the other lanes. Lane i is rdata[127-8i -: 8], so lane 0 is the most significant byte.
- R3: A tail access makes exactly shift byte accesses, starting at addr with its low four bits cleared and increasing by one.
- R4: A tail load places the byte from base+i in lane 16-shift+i and zero in lanes 0 to 15-shift.
- R5: A tail access with shift 0 makes no memory access and raises done in the cycle after acceptance. For a load, the result is all zero.
- R6: A head store writes lanes 0 to 15-shift of req_wdata to addr onward. A tail store writes lanes 16-shift to 15 to base onward. Both write in increasing address order, with mem_we high.
- R7: The memory port has one outstanding access. While mem_req is high and mem_ready is low, mem_addr, mem_we and mem_wdata hold their values. Each cycle with both high completes one byte.
- R8: done is a single-cycle pulse in the cycle after the last byte access completes. busy is high from the cycle after acceptance through the done cycle.
- R9: A request presented while busy is high is ignored. It causes no access and does not change the running access or its result.
- R10: After reset, busy, done and mem_req are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while busy is low |
| req_addr | input | 32 | Effective byte address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_tail | input | 1 | 1 = tail side, 0 = head side |
| req_wdata | input | 128 | Store vector, lane 0 in the top byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 128 | Load result, valid from done until the next acceptance |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Byte access is a write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | 8 | Read byte, sampled with mem_ready |

## Verification
Head and tail loads are applied at shifts 3, 15 and 0 to separate the lane-placement rules and the byte count. Shift 15 gives one byte on the head side and fifteen on the tail side, and shift 0 gives a full head access and an empty tail access. Stores on both sides at one unaligned address show whether the written lanes come from the correct end of the vector. An access just below the top of the address space exercises address formation there. Each memory byte returns a value that depends on its address, and the responder inserts a rotating number of stall cycles. A misplaced lane, a skipped or extra access, or a request that changes while stalled is therefore caught. Requests presented while busy carry a different address and side, so an accidental acceptance would produce visible extra accesses.

// File: rtl/vsplit_pkg.sv
package vsplit_pkg;

    localparam int VS_ADDR_W = 32;
    localparam int VS_LANES  = 16;
    localparam int VS_BYTE_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MOVE = 2'd1,
        SEQ_DONE = 2'd2
    } seq_e;

    typedef enum logic {
        SIDE_HEAD = 1'b0,
        SIDE_TAIL = 1'b1
    } side_e;

endpackage

// File: rtl/vsplit_plan.sv
module vsplit_plan
    import vsplit_pkg::*;
#(
    parameter int ADDR_W = VS_ADDR_W,
    parameter int LANES  = VS_LANES,
    localparam int OFF_W = $clog2(LANES),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  side_e             side,
    output logic [ADDR_W-1:0] start_addr,
    output logic [OFF_W-1:0]  start_lane,
    output logic [CNT_W-1:0]  count
);
    logic [OFF_W-1:0] shift;
    assign shift = addr[OFF_W-1:0];

    always_comb begin
        if (side == SIDE_HEAD) begin
            start_addr = addr;
            start_lane = '0;
            count      = CNT_W'(LANES) - CNT_W'(shift);
        end else begin
            start_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            start_lane = OFF_W'(CNT_W'(LANES) - CNT_W'(shift));
            count      = CNT_W'(shift);
        end
    end

    // R1 / R3: byte count never exceeds one block
    always_comb begin
        a_r3_count_range: assert (count <= CNT_W'(LANES))
            else $error("plan count out of range");
    end

endmodule

// File: rtl/vsplit_lanes.sv
module vsplit_lanes #(
    parameter int LANES  = 16,
    parameter int BYTE_W = 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int VEC_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_all,
    input  logic [VEC_W-1:0]  vec_in,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_lane,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [OFF_W-1:0]  rd_lane,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [VEC_W-1:0]  vec_out
);
    logic [BYTE_W-1:0] bytes_q [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int LO = (LANES - 1 - i) * BYTE_W;

        always_ff @(posedge clk) begin
            if (rst) begin
                bytes_q[i] <= '0;
            end else if (load_all) begin
                bytes_q[i] <= vec_in[LO +: BYTE_W];
            end else if (clear) begin
                bytes_q[i] <= '0;
            end else if (wr_en && (wr_lane == OFF_W'(i))) begin
                bytes_q[i] <= wr_byte;
            end
        end

        assign vec_out[LO +: BYTE_W] = bytes_q[i];
    end

    assign rd_byte = bytes_q[rd_lane];

endmodule

// File: rtl/vsplit_xfer.sv
module vsplit_xfer
    import vsplit_pkg::*;
#(
    parameter int ADDR_W = VS_ADDR_W,
    parameter int LANES  = VS_LANES,
    parameter int BYTE_W = VS_BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    input  logic [ADDR_W-1:0]         req_addr,
    input  logic                      req_store,
    input  logic                      req_tail,
    input  logic [LANES*BYTE_W-1:0]   req_wdata,
    output logic                      busy,
    output logic                      done,
    output logic [LANES*BYTE_W-1:0]   rdata,
    output logic                      mem_req,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [BYTE_W-1:0]         mem_wdata,
    input  logic                      mem_ready,
    input  logic [BYTE_W-1:0]         mem_rdata
);
    localparam int OFF_W = $clog2(LANES);
    localparam int CNT_W = OFF_W + 1;

    seq_e              state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [OFF_W-1:0]  lane_q;
    logic [CNT_W-1:0]  left_q;
    logic              store_q;

    logic [ADDR_W-1:0] plan_addr;
    logic [OFF_W-1:0]  plan_lane;
    logic [CNT_W-1:0]  plan_count;
    logic              accept;
    logic              beat;

    assign accept = req_valid && (state_q == SEQ_IDLE);
    assign beat   = (state_q == SEQ_MOVE) && mem_ready;

    vsplit_plan #(.ADDR_W(ADDR_W), .LANES(LANES)) u_plan (
        .addr       (req_addr),
        .side       (side_e'(req_tail)),
        .start_addr (plan_addr),
        .start_lane (plan_lane),
        .count      (plan_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            lane_q  <= '0;
            left_q  <= '0;
            store_q <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (accept) begin
                    addr_q  <= plan_addr;
                    lane_q  <= plan_lane;
                    left_q  <= plan_count;
                    store_q <= req_store;
                    state_q <= (plan_count == '0) ? SEQ_DONE : SEQ_MOVE;
                end
                SEQ_MOVE: if (mem_ready) begin
                    addr_q <= addr_q + ADDR_W'(1);
                    lane_q <= lane_q + OFF_W'(1);
                    left_q <= left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) state_q <= SEQ_DONE;
                end
                SEQ_DONE: state_q <= SEQ_IDLE;
                default:  state_q <= SEQ_IDLE;
            endcase
        end
    end

    // One lane register serves as store source and load gather buffer
    vsplit_lanes #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lanes (
        .clk      (clk),
        .rst      (rst),
        .load_all (accept && req_store),
        .vec_in   (req_wdata),
        .clear    (accept && !req_store),
        .wr_en    (beat && !store_q),
        .wr_lane  (lane_q),
        .wr_byte  (mem_rdata),
        .rd_lane  (lane_q),
        .rd_byte  (mem_wdata),
        .vec_out  (rdata)
    );

    assign busy     = (state_q != SEQ_IDLE);
    assign done     = (state_q == SEQ_DONE);
    assign mem_req  = (state_q == SEQ_MOVE);
    assign mem_we   = store_q;
    assign mem_addr = addr_q;

    // R7: a stalled access keeps its address, direction and data
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)))
        else $error("stalled access changed");

    // R1 / R3: consecutive accesses step the address by one
    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready) |=> (!mem_req || (mem_addr == $past(mem_addr) + ADDR_W'(1))))
        else $error("address did not step by one");

    // R8: done lasts a single cycle
    a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done)
        else $error("done longer than one cycle");

    // R5: aligned tail access finishes at once without memory traffic
    a_r5_empty: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && req_tail && (req_addr[OFF_W-1:0] == '0))
            |=> (done && !mem_req))
        else $error("empty tail access touched memory");

    // R10: idle unit is quiet on the memory port
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_req && !done))
        else $error("idle unit active");

endmodule

// File: tb/vsplit_xfer_tb.sv
module vsplit_xfer_tb;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst;
    logic         req_valid;
    logic [31:0]  req_addr;
    logic         req_store;
    logic         req_tail;
    logic [127:0] req_wdata;
    logic         busy;
    logic         done;
    logic [127:0] rdata;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [7:0]   mem_wdata;
    logic         mem_ready = 1'b0;
    logic [7:0]   mem_rdata = 8'h00;

    vsplit_xfer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_store(req_store), .req_tail(req_tail), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    typedef struct {
        logic [31:0] a;
        logic        we;
        logic [7:0]  d;
    } acc_t;

    acc_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    int   cyc = 0;
    int   grant_cyc = 0;
    int   wait_cnt = 0;
    int   pat = 0;
    logic        held_valid = 1'b0;
    logic [31:0] held_addr = '0;
    bit          finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mem_val(logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] lane_of(logic [127:0] v, int i);
        return v[(15 - i) * 8 +: 8];
    endfunction

    task automatic check(bit ok, string req, string what,
                         logic [127:0] act, logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Memory responder and access monitor (scoreboard pop side)
    always @(negedge clk) begin
        acc_t e;
        if (held_valid && mem_req)
            check(mem_addr == held_addr, "R7", "address moved while stalled",
                  128'(mem_addr), 128'(held_addr));
        held_valid = 1'b0;
        if (mem_req) begin
            mem_rdata = mem_val(mem_addr);
            if (wait_cnt == 0) begin
                mem_ready = 1'b1;
                grant_cyc = cyc;
                pat = (pat + 1) % 4;
                wait_cnt = pat;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected access", 128'(mem_addr), 128'(0));
                end else begin
                    e = exp_q.pop_front();
                    check(mem_addr == e.a, "R1", "access address",
                          128'(mem_addr), 128'(e.a));
                    check(mem_we == e.we, "R6", "access direction",
                          128'(mem_we), 128'(e.we));
                    if (e.we)
                        check(mem_wdata == e.d, "R6", "write byte",
                              128'(mem_wdata), 128'(e.d));
                end
            end else begin
                mem_ready = 1'b0;
                wait_cnt--;
                held_valid = 1'b1;
                held_addr = mem_addr;
            end
        end else begin
            mem_ready = 1'b0;
        end
    end

    // Driver: computes expected accesses and result, pushes them, runs the request
    task automatic do_op(input logic [31:0] addr, input bit store, input bit tail,
                         input logic [127:0] wd, input bit poke, input string rq);
        int shift;
        int n;
        int start;
        logic [31:0] base;
        logic [127:0] expv;
        int guard;
        acc_t e;
        shift = int'(addr[3:0]);
        if (!tail) begin
            n = 16 - shift; start = 0; base = addr;
        end else begin
            n = shift; start = 16 - shift; base = {addr[31:4], 4'h0};
        end
        expv = '0;
        for (int i = 0; i < n; i++) begin
            e.a  = base + 32'(i);
            e.we = store;
            e.d  = store ? lane_of(wd, start + i) : 8'h00;
            exp_q.push_back(e);
            expv[(15 - (start + i)) * 8 +: 8] = mem_val(base + 32'(i));
        end
        @(negedge clk);
        check(busy == 1'b0, "R8", "busy before request", 128'(busy), 128'(0));
        req_valid = 1'b1; req_addr = addr; req_store = store;
        req_tail = tail; req_wdata = wd;
        @(negedge clk);
        req_valid = poke;
        req_addr  = addr ^ 32'h0000_0005;
        req_tail  = ~tail;
        check(busy == 1'b1, "R8", "busy after acceptance", 128'(busy), 128'(1));
        if (n == 0) begin
            check(done == 1'b1, "R5", "done right after empty request",
                  128'(done), 128'(1));
            check(mem_req == 1'b0, "R5", "no memory request", 128'(mem_req), 128'(0));
        end
        guard = 0;
        while (!done && guard < 500) begin
            @(negedge clk);
            req_valid = 1'b0;
            guard++;
        end
        req_valid = 1'b0;
        if (!done) begin
            check(1'b0, "R8", "done never came", 128'(0), 128'(1));
        end else begin
            if (n > 0)
                check(cyc == grant_cyc + 1, "R8", "done one cycle after last byte",
                      128'(cyc), 128'(grant_cyc + 1));
            check(exp_q.size() == 0, rq, "missing accesses",
                  128'(exp_q.size()), 128'(0));
            if (!store)
                check(rdata == expv, rq, "load vector", rdata, expv);
        end
        exp_q.delete();
        @(negedge clk);
        check(!done && !busy, "R8", "done single pulse, then idle",
              128'({done, busy}), 128'(0));
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0;
        req_store = 1'b0; req_tail = 1'b0; req_wdata = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R10",
              "reset outputs", 128'({busy, done, mem_req}), 128'(0));
        rst = 1'b0;

        do_op(32'h1000_0013, 1'b0, 1'b0, '0, 1'b0, "R2");
        do_op(32'h1000_0023, 1'b0, 1'b1, '0, 1'b0, "R4");
        do_op(32'h2000_0040, 1'b0, 1'b0, '0, 1'b0, "R1");
        do_op(32'h2000_0050, 1'b0, 1'b1, '0, 1'b0, "R5");
        do_op(32'h0000_00AF, 1'b0, 1'b0, '0, 1'b0, "R2");
        do_op(32'h0000_00BF, 1'b0, 1'b1, '0, 1'b0, "R3");
        do_op(32'h3000_0007, 1'b1, 1'b0,
              128'h00112233_44556677_8899AABB_CCDDEEFF, 1'b0, "R6");
        do_op(32'h3000_0007, 1'b1, 1'b1,
              128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 1'b0, "R6");
        do_op(32'h3000_0010, 1'b1, 1'b1,
              128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 1'b0, "R5");
        do_op(32'h3000_0020, 1'b0, 1'b1, '0, 1'b0, "R5");
        do_op(32'hFFFF_FFF9, 1'b0, 1'b0, '0, 1'b0, "R1");
        do_op(32'h4000_0002, 1'b0, 1'b0, '0, 1'b1, "R9");
        do_op(32'h4000_000C, 1'b0, 1'b1, '0, 1'b1, "R9");

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule